// File: doc/BRIEF.md
# Multi-Operand Carry-Save Summation Tree

This block adds a parameterised number of unsigned operands, all of the same width, and delivers one ordinary binary total. The operands enter together as one packed array. They are not added pairwise. Each level of a tree of 3:2 compressors takes groups of three vectors and turns each group into two vectors, a bit-wise sum and a carry. The carry is moved up one bit position because each carry bit weighs twice its column. No carry travels sideways inside a level, so the delay of a level is one full-adder cell whatever the width. When only two vectors are left, a single carry-propagate adder resolves them into the result.

The result is wide enough that the largest possible total always fits. A parameter can place a register after every compressor level, and a second parameter can place one after the final adder. A valid flag travels alongside the data, so a consumer only has to follow `out_valid`. A typical use is summing partial products, or accumulating many samples in one clock.

Top module: `csa_tree_adder`

## Requirements
- R1: When `out_valid` is 1, `result` equals the unsigned sum of all `N_OPS` operands that were presented together with the matching `in_valid`.
- R2: `result` is `OP_W + ceil(log2(N_OPS))` bits wide. With every operand at all ones, the output is `N_OPS*(2^OP_W-1)` with no wrap. For the defaults this is 9*255 = 2295 in 12 bits.
- R3: Each compressor bit position is a full adder of its own. The sum bit is the XOR of the three inputs, and the carry bit is their majority, placed one column higher. The carry out of the top column is always 0.
- R4: A level holding n vectors produces 2*floor(n/3) + (n mod 3) vectors. The one or two vectors left over after grouping pass through unchanged. Levels are added until two vectors remain, so the default of 9 operands takes 4 levels (9, 6, 4, 3, 2).
- R5: The latency from `in_valid` to `out_valid` is the level count when `LEVEL_REG`=1 (0 when it is 0), plus 1 when `OUT_REG`=1. The defaults give 5 clock cycles.
- R6: `out_valid` is `in_valid` delayed by exactly the latency of R5. A bubble (`in_valid`=0) comes out as `out_valid`=0 in the matching cycle.
- R7: While `rst_n` is 0, `out_valid` and `result` are 0. Any work in flight when reset is applied is discarded, so no `out_valid` appears for it after reset is released.
- R8: Every level keeps the arithmetic total. The sum of a level's output vectors equals the sum of its input vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Marks the operand array as valid this cycle |
| ops | input | N_OPS*OP_W | Packed operand array, operand i in bits [i*OP_W +: OP_W] |
| out_valid | output | 1 | `result` holds a completed sum |
| result | output | OP_W+$clog2(N_OPS) | Non-redundant total of the operands |

## Verification
The bench drives all-ones operands in every slot to test the width rule. A design that dropped the top carry column or sized the result one bit short would wrap, and 2295 would come back smaller. It places a single maximal operand in each slot in turn. A mistake in the leftover pass-through, or in the way levels are wired to each other, would lose that operand or count it twice. Alternating 0xAA/0x55 patterns and random data with random bubbles check carry weighting and the valid timing; a carry left unshifted halves its weight, and an off-by-one pipeline pairs totals with the wrong flag. A reset applied mid-stream must flush every pending valid, which catches data registers or flags that outlive the reset.

// File: rtl/csa_pkg.sv
package csa_pkg;

   // Vector count after one 3:2 level: each full group of three gives two.
   function automatic int next_cnt(input int n);
      return (n / 3) * 2 + (n % 3);
   endfunction

   // Number of compressor levels needed to reach two vectors.
   function automatic int num_levels(input int n);
      int cnt;
      int lv;
      cnt = n;
      lv  = 0;
      while (cnt > 2) begin
         cnt = next_cnt(cnt);
         lv++;
      end
      return lv;
   endfunction

   // Vector count entering level lvl of a tree that starts with n0 vectors.
   function automatic int cnt_at(input int n0, input int lvl);
      int cnt;
      cnt = n0;
      for (int i = 0; i < lvl; i++) cnt = next_cnt(cnt);
      return cnt;
   endfunction

endpackage

// File: rtl/csa_full_adder.sv
// One column of a compressor, in the mux-based form: the half-sum
// picks between the carry-in and its inverse, and between carry-in and b.
module csa_full_adder (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   logic hs;

   assign hs = a ^ b;
   assign s  = hs ? ~ci : ci;
   assign co = hs ? ci : b;

endmodule

// File: rtl/csa_fa_row.sv
// 3:2 compressor over WIDTH independent columns; no lateral carry.
module csa_fa_row #(
   parameter int WIDTH = 12
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic [WIDTH-1:0] z,
   output logic [WIDTH-1:0] sum,
   output logic [WIDTH-1:0] carry_sh,
   output logic             carry_msb
);
   logic [WIDTH-1:0] cy;

   if (WIDTH < 2) begin : g_bad_width
      $error("csa_fa_row: WIDTH must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_col
      csa_full_adder u_fa (
         .a  (x[b]),
         .b  (y[b]),
         .ci (z[b]),
         .s  (sum[b]),
         .co (cy[b])
      );
   end

   // carry bit b weighs 2^(b+1)
   assign carry_sh  = {cy[WIDTH-2:0], 1'b0};
   assign carry_msb = cy[WIDTH-1];

endmodule

// File: rtl/csa_level.sv
// One level of the tree: groups of three are compressed, the remainder
// passes through, and an optional register closes the level.
module csa_level
   import csa_pkg::*;
#(
   parameter int N_IN = 9,
   parameter int RW   = 12,
   parameter bit REG  = 1'b1,
   localparam int N_OUT = next_cnt(N_IN)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       vld_in,
   input  logic [N_IN-1:0][RW-1:0]    vin,
   output logic                       vld_out,
   output logic [N_OUT-1:0][RW-1:0]   vout
);
   localparam int GRP = N_IN / 3;
   localparam int REM = N_IN % 3;
   localparam int SW  = RW + $clog2(N_IN + 1) + 1;

   if (N_IN < 3) begin : g_bad_count
      $error("csa_level: a level needs at least three input vectors");
   end

   logic [N_OUT-1:0][RW-1:0] nxt;
   logic [GRP-1:0]           drop;

   for (genvar g = 0; g < GRP; g++) begin : g_grp
      csa_fa_row #(.WIDTH(RW)) u_row (
         .x         (vin[3*g]),
         .y         (vin[3*g+1]),
         .z         (vin[3*g+2]),
         .sum       (nxt[2*g]),
         .carry_sh  (nxt[2*g+1]),
         .carry_msb (drop[g])
      );
   end

   for (genvar k = 0; k < REM; k++) begin : g_left
      assign nxt[2*GRP+k] = vin[3*GRP+k];
   end

   if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_out <= 1'b0;
            vout    <= '0;
         end else begin
            vld_out <= vld_in;
            vout    <= nxt;
         end
      end
   end else begin : g_comb
      assign vld_out = vld_in;
      assign vout    = nxt;
   end

   // totals on both sides of the compressors, wide enough not to wrap
   logic [SW-1:0] tot_in;
   logic [SW-1:0] tot_out;
   always_comb begin
      tot_in  = '0;
      tot_out = '0;
      for (int i = 0; i < N_IN; i++)  tot_in  = tot_in  + SW'(vin[i]);
      for (int i = 0; i < N_OUT; i++) tot_out = tot_out + SW'(nxt[i]);
   end

   // R3: the top-column carry never carries weight out of the result width
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vld_in |-> (drop == '0));

   // R8: compression conserves the arithmetic total of the level
   p_conserve_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vld_in |-> (tot_in == tot_out));

endmodule

// File: rtl/csa_cpa.sv
// Final carry-propagate adder resolving the last sum/carry pair.
module csa_cpa #(
   parameter int RW      = 12,
   parameter bit RIPPLE  = 1'b1,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_in,
   input  logic [RW-1:0] a,
   input  logic [RW-1:0] b,
   output logic          vld_out,
   output logic [RW-1:0] sum
);
   logic [RW-1:0] add_q;

   if (RIPPLE) begin : g_ripple
      logic [RW:0]   c;
      logic [RW-1:0] gen;
      logic [RW-1:0] prp;
      assign c[0] = 1'b0;
      for (genvar i = 0; i < RW; i++) begin : g_bit
         assign gen[i]   = a[i] & b[i];
         assign prp[i]   = a[i] ^ b[i];
         assign c[i+1]   = gen[i] | (prp[i] & c[i]);
         assign add_q[i] = prp[i] ^ c[i];
      end
   end else begin : g_behav
      assign add_q = a + b;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_out <= 1'b0;
            sum     <= '0;
         end else begin
            vld_out <= vld_in;
            sum     <= add_q;
         end
      end
   end else begin : g_comb
      assign vld_out = vld_in;
      assign sum     = add_q;
   end

   logic [RW:0] wide_chk;
   assign wide_chk = {1'b0, a} + {1'b0, b};

   // R2: the redundant pair never sums past the result width
   p_cpa_no_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      vld_in |-> (wide_chk[RW] == 1'b0));

endmodule

// File: rtl/csa_tree_adder.sv
module csa_tree_adder
   import csa_pkg::*;
#(
   parameter int N_OPS      = 9,
   parameter int OP_W       = 8,
   parameter bit LEVEL_REG  = 1'b1,
   parameter bit OUT_REG    = 1'b1,
   parameter bit CPA_RIPPLE = 1'b1,
   localparam int RES_W     = OP_W + $clog2(N_OPS),
   localparam int NLEV      = num_levels(N_OPS),
   localparam int LATENCY   = (LEVEL_REG ? NLEV : 0) + (OUT_REG ? 1 : 0)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [N_OPS-1:0][OP_W-1:0]  ops,
   output logic                        out_valid,
   output logic [RES_W-1:0]            result
);
   if (N_OPS < 3) begin : g_bad_ops
      $error("csa_tree_adder: N_OPS must be at least 3");
   end
   if (OP_W < 1) begin : g_bad_width
      $error("csa_tree_adder: OP_W must be at least 1");
   end

   for (genvar l = 0; l < NLEV; l++) begin : g_lvl
      localparam int NI = cnt_at(N_OPS, l);
      localparam int NO = next_cnt(NI);

      logic [NI-1:0][RES_W-1:0] vin;
      logic                     vin_vld;
      logic [NO-1:0][RES_W-1:0] vout;
      logic                     vout_vld;

      if (l == 0) begin : g_src
         for (genvar i = 0; i < N_OPS; i++) begin : g_ext
            assign vin[i] = {{(RES_W-OP_W){1'b0}}, ops[i]};
         end
         assign vin_vld = in_valid;
      end else begin : g_chain
         assign vin     = g_lvl[l-1].vout;
         assign vin_vld = g_lvl[l-1].vout_vld;
      end

      csa_level #(
         .N_IN (NI),
         .RW   (RES_W),
         .REG  (LEVEL_REG)
      ) u_lvl (
         .clk     (clk),
         .rst_n   (rst_n),
         .vld_in  (vin_vld),
         .vin     (vin),
         .vld_out (vout_vld),
         .vout    (vout)
      );
   end

   csa_cpa #(
      .RW      (RES_W),
      .RIPPLE  (CPA_RIPPLE),
      .OUT_REG (OUT_REG)
   ) u_cpa (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_in  (g_lvl[NLEV-1].vout_vld),
      .a       (g_lvl[NLEV-1].vout[0]),
      .b       (g_lvl[NLEV-1].vout[1]),
      .vld_out (out_valid),
      .sum     (result)
   );

   localparam logic [RES_W-1:0] MAX_SUM =
      RES_W'(N_OPS) * {{(RES_W-OP_W){1'b0}}, {OP_W{1'b1}}};

   // R1: a completed total can never exceed the sum of N maximal operands
   p_result_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (result <= MAX_SUM));

endmodule

// File: tb/csa_tree_adder_tb_top.sv
`timescale 1ns/1ps
module csa_tree_adder_tb_top;
   localparam int N    = 9;
   localparam int W    = 8;
   localparam int RW   = W + $clog2(N);
   localparam int HMAX = 4096;

   // latency from the requirements: levels by 2*floor(n/3)+n%3, plus output reg
   function automatic int exp_latency();
      int n;
      int lv;
      n  = N;
      lv = 0;
      while (n > 2) begin
         n = (n / 3) * 2 + (n % 3);
         lv++;
      end
      return lv + 1;
   endfunction

   localparam int LAT = exp_latency();

   logic                  clk;
   logic                  rst_n;
   logic                  in_valid;
   logic [N-1:0][W-1:0]   ops;
   logic                  out_valid;
   logic [RW-1:0]         result;

   csa_tree_adder #(.N_OPS(N), .OP_W(W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .ops       (ops),
      .out_valid (out_valid),
      .result    (result)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   int n_run;
   int n_fail;
   int t;
   logic          hv [HMAX];
   logic [RW-1:0] hs [HMAX];
   string         tag;

   function automatic logic [RW-1:0] ref_sum(input logic [N-1:0][W-1:0] v);
      logic [RW-1:0] acc;
      acc = '0;
      for (int i = 0; i < N; i++) acc = acc + RW'(v[i]);
      return acc;
   endfunction

   task automatic check(input string req, input logic [RW-1:0] act,
                        input logic [RW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d (t=%0d)", req, act, exp, t);
      end
   endtask

   // one cycle: compare outputs due now, then drive the next inputs
   task automatic tick(input logic [N-1:0][W-1:0] v, input logic vld);
      @(negedge clk);
      if (t >= LAT) begin
         check("R6", RW'(out_valid), RW'(hv[t-LAT]));
         if (hv[t-LAT]) check(tag, result, hs[t-LAT]);
      end
      ops      = v;
      in_valid = vld;
      hv[t]    = vld;
      hs[t]    = ref_sum(v);
      t++;
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [N-1:0][W-1:0] v;
      logic [31:0]         seed_dummy;
      n_run    = 0;
      n_fail   = 0;
      t        = 0;
      rst_n    = 1'b0;
      in_valid = 1'b0;
      ops      = '0;
      tag      = "R1";
      seed_dummy = $urandom(32'd1234);

      // R7: reset state
      repeat (3) @(negedge clk);
      check("R7", RW'(out_valid), '0);
      check("R7", result, '0);
      rst_n = 1'b1;

      // R1: all zeros
      tag = "R1";
      tick('0, 1'b1);
      // R2: all ones, maximal total 2295
      tag = "R2";
      tick({N{ {W{1'b1}} }}, 1'b1);
      tick({N{ {W{1'b1}} }}, 1'b1);
      // R4: a single maximal operand in each slot (leftover pass-through)
      tag = "R4";
      for (int i = 0; i < N; i++) begin
         v = '0;
         v[i] = {W{1'b1}};
         tick(v, 1'b1);
      end
      // R3: alternating patterns stress carry weighting
      tag = "R3";
      for (int i = 0; i < N; i++) v[i] = (i % 2) ? 8'hAA : 8'h55;
      tick(v, 1'b1);
      for (int i = 0; i < N; i++) v[i] = 8'hAA;
      tick(v, 1'b1);
      // R8: walking single bits across all operands
      tag = "R8";
      for (int b = 0; b < W; b++) begin
         for (int i = 0; i < N; i++) v[i] = W'(1) << b;
         tick(v, 1'b1);
      end
      // R5/R6: an isolated valid surrounded by bubbles
      tag = "R5";
      for (int i = 0; i < N; i++) v[i] = W'(i * 17 + 3);
      tick(v, 1'b1);
      repeat (LAT + 1) tick('0, 1'b0);
      // R1/R6: random data with random bubbles
      tag = "R1";
      for (int c = 0; c < 1500; c++) begin
         for (int i = 0; i < N; i++) v[i] = W'($urandom);
         tick(v, ($urandom % 4) != 0);
      end
      repeat (LAT) tick('0, 1'b0);

      // R7: reset mid-stream flushes pending valids
      tag = "R7";
      for (int c = 0; c < LAT - 1; c++) tick({N{ {W{1'b1}} }}, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      check("R7", RW'(out_valid), '0);
      check("R7", result, '0);
      rst_n = 1'b1;
      for (int c = 0; c < LAT + 2; c++) begin
         @(negedge clk);
         check("R7", RW'(out_valid), '0);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule